// File: doc/BRIEF.md
# Multi-Source Supply Latch Controller

This block decides whether the main supply enable of a radio is on. Four sources can keep it on: a supply hold that the controller itself holds on behalf of software, an emergency switch, a front-panel power key, and an ignition sense. The ignition sense arrives as two comparator outputs, one meaning "above the upper threshold" and one meaning "below the lower threshold". All inputs are debounced, synchronous levels. Two event inputs are single-cycle pulses: a key press reported while the unit is running, and a "handling finished" pulse from software after an emergency wake.

The supply hold is a small state machine. It leaves the off state when the emergency switch, the power key or the ignition level rises, and the source that rose is recorded in a sticky wake-cause flag for the processor. A key press while running starts a fixed shutdown delay, and the hold drops when the delay ends. An emergency wake from off lasts until software reports that the handling is finished. An ignition wake lasts until ignition falls below the lower threshold. The supply enable is a register: it is the OR of the next hold state and the three hardware paths.

Top module: `pwr_latch_ctrl`

## Requirements
- R1: `supply_en` is registered. After each rising clock edge it equals the OR of `emerg_in`, `key_in`, the ignition level and the supply hold, all as sampled at that edge. It is therefore high whenever `hold_on` is high.
- R2: While `rst_n` is low at a clock edge, `supply_en`, `hold_on` and all three wake flags go low after that edge.
- R3: When `emerg_in` rises while the hold is off, the hold sets on the same edge and `wake_emerg` sets. Both stay set after `emerg_in` is released.
- R4: After an emergency wake from off, a `emerg_done` pulse clears the hold. With no hardware path active, `supply_en` falls on that same edge.
- R5: When `emerg_in` rises while the hold is already on, the hold stays set, `wake_emerg` is not set, and `emerg_done` has no effect.
- R6: The ignition level sets when `ign_above_hi` is 1, clears when `ign_below_lo` is 1, and otherwise keeps its value. If the hold is off, its rising sets the hold and `wake_ign`. An ignition-started hold clears on the edge where the level falls. While the level sits between the thresholds, nothing changes. An ignition fall does not clear a hold started by the key or by the emergency switch.
- R7: When `key_in` rises while the hold is off, the hold sets and `wake_key` sets. The hold stays set after the key is released.
- R8: A `key_press_evt` pulse sampled at edge e, with the hold on, clears the hold at edge e+`SHUTDOWN_CYCLES`. Further pulses during that wait neither restart nor extend it.
- R9: Wake flags stay set until a `flag_clr` pulse. A flag that is being set on the same edge as a clear stays set.
- R10: When several sources rise on the same edge while the hold is off, every source that rose sets its own flag, and the hold sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| emerg_in | input | 1 | Emergency switch engaged (level) |
| key_in | input | 1 | Power key held (level) |
| ign_above_hi | input | 1 | Ignition above upper threshold |
| ign_below_lo | input | 1 | Ignition below lower threshold |
| key_press_evt | input | 1 | One-cycle pulse: key pressed while running |
| emerg_done | input | 1 | One-cycle pulse: emergency handling finished |
| flag_clr | input | 1 | One-cycle pulse: clear wake flags |
| supply_en | output | 1 | Registered main supply enable |
| hold_on | output | 1 | Supply hold currently set |
| wake_emerg | output | 1 | Sticky flag: woke by emergency |
| wake_key | output | 1 | Sticky flag: woke by power key |
| wake_ign | output | 1 | Sticky flag: woke by ignition |

## Verification
The bench sweeps every combination of the three wake sources from reset. It expects the enable, the hold and each flag to match the set of sources that rose. A design that took only one flag, or let the hold follow a level, fails there.

The shutdown wait is checked on every edge, with a second press sent partway through. An off-by-one counter, or one that restarts on the second press, shows up as the enable falling one edge early or late.

The ignition checks cover the band between the thresholds, where a design without hysteresis would drop power. They also cover an ignition fall during a key-started run, which must not end that run. An emergency raised while already running must not take the run over, and its `emerg_done` pulse must leave the unit on.

// File: rtl/pwr_latch_pkg.sv
// Shared types for the supply latch controller.
// Assumes: included first in compile order.
package pwr_latch_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_RUN       = 3'd1,
        ST_IGN_RUN   = 3'd2,
        ST_EMERG_RUN = 3'd3,
        ST_DOWN_WAIT = 3'd4
    } pwr_state_e;

    localparam int SRC_EMERG = 0;
    localparam int SRC_KEY   = 1;
    localparam int N_EDGE    = 2;

endpackage

// File: rtl/pwr_edge_det.sv
// Rising-edge detector for a vector of synchronous levels.
// Assumes: inputs are already synchronous and debounced; after reset the
// previous value is 0, so a level that is high out of reset reads as a rise.
module pwr_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic prev_q;

        // remember the last sampled level of this bit
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl[g];
        end

        assign rise[g] = lvl[g] & ~prev_q;
    end

endmodule

// File: rtl/pwr_ign_hyst.sv
// Ignition hysteresis latch built from two comparator outputs.
// Assumes: both comparators high together is invalid; the latch then keeps
// its value.
module pwr_ign_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic above_hi,
    input  logic below_lo,
    output logic lvl_next,
    output logic lvl_q
);

    // decide the next latch value from the two thresholds
    always_comb begin
        if (above_hi && !below_lo)      lvl_next = 1'b1;
        else if (below_lo && !above_hi) lvl_next = 1'b0;
        else                            lvl_next = lvl_q;
    end

    // store the latch
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_next;
    end

    AST_IGN_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!above_hi && !below_lo) |=> $stable(lvl_q)); // R6

endmodule

// File: rtl/pwr_shutdown_timer.sv
// Down-counter for the delayed key shutdown.
// Assumes: load comes as a single pulse on the edge where the wait begins;
// run stays high for the whole wait. expired goes high in the last wait cycle.
module pwr_shutdown_timer #(
    parameter int DELAY = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] START = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    // load on entry to the wait, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load)                    cnt_q <= START;
        else if (run && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
    end

    assign expired = run && (cnt_q == '0);

    AST_TIMER_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

    AST_TIMER_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !load); // R8

endmodule

// File: rtl/pwr_latch_ctrl.sv
// Multi-source supply latch controller.
// Holds the supply on for software, ORs in the emergency, key and ignition
// paths, and records which source woke the unit.
// Assumes: synchronous debounced inputs; key_press_evt, emerg_done and
// flag_clr are one-cycle pulses.
module pwr_latch_ctrl
    import pwr_latch_pkg::*;
#(
    parameter int SHUTDOWN_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic emerg_in,
    input  logic key_in,
    input  logic ign_above_hi,
    input  logic ign_below_lo,
    input  logic key_press_evt,
    input  logic emerg_done,
    input  logic flag_clr,
    output logic supply_en,
    output logic hold_on,
    output logic wake_emerg,
    output logic wake_key,
    output logic wake_ign
);

    pwr_state_e          state_q, state_d;
    logic [N_EDGE-1:0]   rise;
    logic                ign_next, ign_q, ign_rise;
    logic                timer_load, timer_run, timer_done;
    logic                off_now;
    logic                set_emerg, set_key, set_ign;

    pwr_edge_det #(.WIDTH(N_EDGE)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({key_in, emerg_in}),
        .rise (rise)
    );

    pwr_ign_hyst i_ign (
        .clk     (clk),
        .rst_n   (rst_n),
        .above_hi(ign_above_hi),
        .below_lo(ign_below_lo),
        .lvl_next(ign_next),
        .lvl_q   (ign_q)
    );

    pwr_shutdown_timer #(.DELAY(SHUTDOWN_CYCLES)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (timer_load),
        .run    (timer_run),
        .expired(timer_done)
    );

    assign ign_rise  = ign_next & ~ign_q;
    assign off_now   = (state_q == ST_OFF);
    assign timer_run = (state_q == ST_DOWN_WAIT);

    // hold state machine: wake from off, keep running, delayed key shutdown
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        case (state_q)
            ST_OFF: begin
                if (rise[SRC_EMERG])    state_d = ST_EMERG_RUN;
                else if (rise[SRC_KEY]) state_d = ST_RUN;
                else if (ign_rise)      state_d = ST_IGN_RUN;
            end
            ST_RUN, ST_IGN_RUN, ST_EMERG_RUN: begin
                if (key_press_evt) begin
                    state_d    = ST_DOWN_WAIT;
                    timer_load = 1'b1;
                end else if (state_q == ST_EMERG_RUN && emerg_done) begin
                    state_d = ST_OFF;
                end else if (state_q == ST_IGN_RUN && !ign_next) begin
                    state_d = ST_OFF;
                end
            end
            ST_DOWN_WAIT: begin
                if (timer_done) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register and the registered supply enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            supply_en <= 1'b0;
        end else begin
            state_q   <= state_d;
            supply_en <= (state_d != ST_OFF) | emerg_in | key_in | ign_next;
        end
    end

    assign set_emerg = off_now & rise[SRC_EMERG];
    assign set_key   = off_now & rise[SRC_KEY];
    assign set_ign   = off_now & ign_rise;

    // sticky wake-cause flags; a set wins over a clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_emerg <= 1'b0;
            wake_key   <= 1'b0;
            wake_ign   <= 1'b0;
        end else begin
            wake_emerg <= set_emerg | (wake_emerg & ~flag_clr);
            wake_key   <= set_key   | (wake_key   & ~flag_clr);
            wake_ign   <= set_ign   | (wake_ign   & ~flag_clr);
        end
    end

    assign hold_on = (state_q != ST_OFF);

    AST_HOLD_KEEPS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        hold_on |-> supply_en); // R1

    AST_EMERG_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (off_now && rise[SRC_EMERG]) |=> (hold_on && wake_emerg)); // R3

    AST_EMERG_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMERG_RUN && emerg_done && !key_press_evt) |=> !hold_on); // R4

    AST_KEY_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (off_now && rise[SRC_KEY]) |=> (hold_on && wake_key)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_key && !flag_clr) |=> wake_key); // R9

endmodule

// File: tb/test_pwr_latch_ctrl.sv
module test_pwr_latch_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic emerg_in = 0, key_in = 0, ign_above_hi = 0, ign_below_lo = 0;
    logic key_press_evt = 0, emerg_done = 0, flag_clr = 0;
    logic supply_en, hold_on, wake_emerg, wake_key, wake_ign;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_latch_ctrl #(.SHUTDOWN_CYCLES(DLY)) i_pwr_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .emerg_in(emerg_in), .key_in(key_in),
        .ign_above_hi(ign_above_hi), .ign_below_lo(ign_below_lo),
        .key_press_evt(key_press_evt), .emerg_done(emerg_done),
        .flag_clr(flag_clr), .supply_en(supply_en), .hold_on(hold_on),
        .wake_emerg(wake_emerg), .wake_key(wake_key), .wake_ign(wake_ign)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        emerg_in = 0; key_in = 0; ign_above_hi = 0; ign_below_lo = 0;
        key_press_evt = 0; emerg_done = 0; flag_clr = 0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
    endtask

    task automatic key_wake();
        key_in = 1; step();
        key_in = 0; step();
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog: got hang expected finish");
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        #1;
        do_reset();
        // R2: quiet after reset
        check(supply_en, 0, "R2", "supply_en");
        check(hold_on, 0, "R2", "hold_on");
        check(wake_emerg | wake_key | wake_ign, 0, "R2", "flags");

        // R1 / R10: every combination of rising sources from off
        for (int c = 0; c < 8; c++) begin
            do_reset();
            emerg_in = c[0]; key_in = c[1]; ign_above_hi = c[2];
            step();
            check(supply_en, c != 0, "R1", "supply_en sweep");
            check(hold_on, c != 0, "R10", "hold sweep");
            check(wake_emerg, c[0], "R10", "wake_emerg sweep");
            check(wake_key, c[1], "R10", "wake_key sweep");
            check(wake_ign, c[2], "R10", "wake_ign sweep");
            emerg_in = 0; key_in = 0; ign_above_hi = 0;
            step();
            check(supply_en, c != 0, "R1", "supply after release");
        end

        // R3 / R4: momentary emergency from off
        do_reset();
        emerg_in = 1; step();
        emerg_in = 0; step(); step(); step();
        check(supply_en, 1, "R3", "supply held after release");
        check(hold_on, 1, "R3", "hold after release");
        check(wake_emerg, 1, "R3", "wake_emerg");
        emerg_done = 1; step(); emerg_done = 0;
        check(hold_on, 0, "R4", "hold cleared");
        check(supply_en, 0, "R4", "supply dropped");

        // R5: emergency while already running
        do_reset();
        key_wake();
        emerg_in = 1; step();
        check(wake_emerg, 0, "R5", "no emergency flag");
        emerg_in = 0; step();
        emerg_done = 1; step(); emerg_done = 0;
        check(hold_on, 1, "R5", "hold kept");
        check(supply_en, 1, "R5", "supply kept");

        // R6: ignition hysteresis
        do_reset();
        ign_above_hi = 1; step();
        check(hold_on, 1, "R6", "ignition wake");
        check(wake_ign, 1, "R6", "wake_ign");
        ign_above_hi = 0; step(); step(); step();
        check(supply_en, 1, "R6", "between thresholds");
        ign_below_lo = 1; step();
        check(supply_en, 0, "R6", "below lower threshold");
        check(hold_on, 0, "R6", "hold dropped");
        ign_below_lo = 0; step();
        check(supply_en, 0, "R6", "stays off in band");
        ign_above_hi = 1; step(); ign_above_hi = 0;
        check(supply_en, 1, "R6", "second ignition wake");
        // ignition fall during a key run
        do_reset();
        key_wake();
        ign_above_hi = 1; step(); ign_above_hi = 0;
        ign_below_lo = 1; step(); ign_below_lo = 0;
        check(hold_on, 1, "R6", "key run survives ignition fall");

        // R7 / R8: key wake, delayed shutdown with a second press inside
        do_reset();
        key_wake();
        check(hold_on, 1, "R7", "hold after key release");
        check(wake_key, 1, "R7", "wake_key");
        key_press_evt = 1; step(); key_press_evt = 0;
        for (int i = 1; i <= DLY; i++) begin
            key_press_evt = (i == 2);
            step();
            key_press_evt = 0;
            check(supply_en, i < DLY, "R8", "shutdown wait edge");
        end
        check(hold_on, 0, "R8", "hold after wait");

        // R8: wait from an emergency run
        do_reset();
        emerg_in = 1; step(); emerg_in = 0;
        key_press_evt = 1; step(); key_press_evt = 0;
        for (int i = 1; i <= DLY; i++) begin
            step();
            check(hold_on, i < DLY, "R8", "emergency run wait");
        end

        // R9: sticky flags and clear
        do_reset();
        key_wake();
        step(); step();
        check(wake_key, 1, "R9", "flag sticky");
        flag_clr = 1; step(); flag_clr = 0;
        check(wake_key, 0, "R9", "flag cleared");
        check(hold_on, 1, "R9", "clear keeps hold");
        // set wins over clear on the same edge
        do_reset();
        key_in = 1; flag_clr = 1; step();
        key_in = 0; flag_clr = 0;
        check(wake_key, 1, "R9", "set beats clear");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule